// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the line sync, frame sync and data-enable window for a 320x240 TFT panel that is fed through a narrow parallel port. Depending on the pixel format chosen on the `mode` input, one pixel occupies one, two or three port clock ticks. Every horizontal interval is scaled by that clocks-per-pixel factor. The start of the visible window also gets a fixed, format-specific pipeline correction. All counts are in port clock ticks.

The generator counts ticks within a line and lines within a frame. From these counts it decodes active-low `hsyncN` and `vsyncN`, a `de` window covering the visible lines, the current line number and the index of the pixel being sent. The pixel format is sampled only at a frame boundary, so a frame never mixes two formats. Deasserting `enable` parks the counters at zero and the syncs high. When `enable` returns, a fresh frame starts. A reserved format code keeps the generator idle.

Top module: `lcd_sync_gen`

## Requirements
- R1: Format codes on `mode`: 2'b00 gives 1 tick per pixel with correction 0, 2'b01 gives 2 ticks per pixel with correction 3, and 2'b10 gives 3 ticks per pixel with correction 5. A line lasts `H_TOTAL` (336) times the ticks per pixel.
- R2: While running, `hsyncN` is 0 for the first `H_PULSE` (2) times ticks-per-pixel ticks of every line and 1 for the rest of the line.
- R3: While running, `vsyncN` is 0 only during the first `V_PULSE` (2) times ticks-per-pixel ticks of line 0, and 1 at all other times.
- R4: A frame holds `ACT_LINES + BLANK_LINES` (244) lines. `lineIdx` steps by one at each line start and wraps from 243 to 0.
- R5: `de` is 1 exactly on ticks `H_START*cpp + corr` up to, but not including, that value plus `ACT_PIX*cpp` (with `H_START` = 7 and `ACT_PIX` = 320). This holds only on lines `BLANK_LINES/2` through `BLANK_LINES/2 + ACT_LINES - 1` (lines 2 to 241).
- R6: While `de` is 1, `pixIdx` equals (tick - window start) / cpp, rounded down, so it starts at 0 and rises by one every cpp ticks. While `de` is 0, `pixIdx` is 0.
- R7: Format code 2'b11 is reserved. When it is present at a frame start, the generator stays idle: `hsyncN` = `vsyncN` = 1, `de` = 0, `lineIdx` = `pixIdx` = 0. It starts on the next edge that sees a valid code.
- R8: A clock edge with `enable` = 0 leaves the generator idle, with the same idle output values. After an edge that sees `enable` = 1 with a valid code while idle, the next cycle is tick 0 of line 0.
- R9: A change on `mode` in the middle of a frame has no effect until the frame ends. The next frame uses the code present on its first edge.
- R10: After a clock edge with `rst` = 1, the outputs hold their idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request; low parks the generator |
| mode | input | 2 | Pixel format code (R1, R7) |
| hsyncN | output | 1 | Line sync, active low |
| vsyncN | output | 1 | Frame sync, active low |
| de | output | 1 | Visible pixel window |
| lineIdx | output | 8 | Current line within the frame |
| pixIdx | output | 9 | Pixel index within the visible window |

## Verification
The checker assumes that `mode` and `enable` change only between clock edges. It also assumes that the geometry parameters leave a gap of at least one tick between the end of the visible window and the next line start. If there were no gap, `de` would run from one line into the next and the pixel-step property would see a jump. The bench drives inputs on the falling edge only and uses a reduced geometry that keeps this gap in every format. It moves `mode` in the middle of frames, drops `enable` in the middle of a line, and raises the reserved code both while idle and just before a frame boundary.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    FMT_WIDE565   = 2'b00,
    FMT_NARROW565 = 2'b01,
    FMT_NARROW888 = 2'b10,
    FMT_RSVD      = 2'b11
  } fmt_e;

  // per-format tick scaling handed from control to datapath
  typedef struct packed {
    logic [1:0] cpp;
    logic [2:0] corr;
  } fmt_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic step;
    logic live;
  } seq_strobe_t;

  function automatic fmt_cfg_t fmtDecode(fmt_e f);
    fmt_cfg_t c;
    case (f)
      FMT_NARROW565: begin c.cpp = 2'd2; c.corr = 3'd3; end
      FMT_NARROW888: begin c.cpp = 2'd3; c.corr = 3'd5; end
      default:       begin c.cpp = 2'd1; c.corr = 3'd0; end
    endcase
    return c;
  endfunction

  function automatic logic fmtValid(fmt_e f);
    return f != FMT_RSVD;
  endfunction

endpackage

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic [1:0]  mode,
  input  logic        frameEnd,
  output seq_strobe_t strobe,
  output fmt_cfg_t    cfg
);

  logic running;
  fmt_e curFmt;
  fmt_e reqFmt;

  assign reqFmt = fmt_e'(mode);

  // format is sampled only when a frame begins
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      curFmt  <= FMT_WIDE565;
    end else if (!enable) begin
      running <= 1'b0;
    end else if (!running) begin
      if (fmtValid(reqFmt)) begin
        running <= 1'b1;
        curFmt  <= reqFmt;
      end
    end else if (frameEnd) begin
      curFmt  <= reqFmt;
      running <= fmtValid(reqFmt);
    end
  end

  always_comb begin
    strobe.live = running;
    strobe.step = running && enable;
    strobe.clr  = !(running && enable);
    cfg         = fmtDecode(curFmt);
  end

endmodule

// File: rtl/lcd_sync_dp.sv
module lcd_sync_dp
  import lcd_sync_pkg::*;
#(
  parameter int ACT_PIX     = 320,
  parameter int ACT_LINES   = 240,
  parameter int BLANK_LINES = 4,
  parameter int H_TOTAL     = 336,
  parameter int H_START     = 7,
  parameter int H_PULSE     = 2,
  parameter int V_PULSE     = 2,
  parameter int LINE_W      = 8,
  parameter int PIX_W       = 9
)(
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       strobe,
  input  fmt_cfg_t          cfg,
  output logic              frameEnd,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              de,
  output logic [LINE_W-1:0] lineIdx,
  output logic [PIX_W-1:0]  pixIdx
);

  localparam int V_TOTAL = ACT_LINES + BLANK_LINES;
  localparam int V_TOP   = BLANK_LINES / 2;
  localparam int V_BOT   = V_TOP + ACT_LINES;
  localparam int H_W     = $clog2(H_TOTAL * 3 + 1);

  logic [H_W-1:0]    hCnt;
  logic [LINE_W-1:0] vCnt;
  logic [1:0]        phase;
  logic [PIX_W-1:0]  pixCnt;

  logic [H_W-1:0] cppH, hLast, hPulseEnd, vPulseEnd, winStart, winStop;
  logic lineEnd, hWin, vWin, syncLow;

  // mode-scaled limits; the multiplier is at most 3
  always_comb begin
    cppH      = H_W'(cfg.cpp);
    hLast     = H_W'(H_TOTAL) * cppH - H_W'(1);
    hPulseEnd = H_W'(H_PULSE) * cppH;
    vPulseEnd = H_W'(V_PULSE) * cppH;
    winStart  = H_W'(H_START) * cppH + H_W'(cfg.corr);
    winStop   = winStart + H_W'(ACT_PIX) * cppH;
  end

  assign lineEnd  = hCnt == hLast;
  assign frameEnd = lineEnd && (vCnt == LINE_W'(V_TOTAL - 1));
  assign hWin     = (hCnt >= winStart) && (hCnt < winStop);
  assign vWin     = (vCnt >= LINE_W'(V_TOP)) && (vCnt < LINE_W'(V_BOT));
  assign syncLow  = hCnt < hPulseEnd;

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) begin
      hCnt   <= '0;
      vCnt   <= '0;
      phase  <= '0;
      pixCnt <= '0;
    end else if (strobe.step) begin
      if (lineEnd) begin
        hCnt   <= '0;
        phase  <= '0;
        pixCnt <= '0;
        vCnt   <= frameEnd ? '0 : vCnt + LINE_W'(1);
      end else begin
        hCnt <= hCnt + H_W'(1);
        if (hWin) begin
          if (phase == cfg.cpp - 2'd1) begin
            phase  <= '0;
            pixCnt <= pixCnt + PIX_W'(1);
          end else begin
            phase <= phase + 2'd1;
          end
        end
      end
    end
  end

  always_comb begin
    hsyncN  = !(strobe.live && syncLow);
    vsyncN  = !(strobe.live && (vCnt == '0) && (hCnt < vPulseEnd));
    de      = strobe.live && hWin && vWin;
    lineIdx = vCnt;
    pixIdx  = de ? pixCnt : '0;
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int ACT_PIX     = 320,
  parameter int ACT_LINES   = 240,
  parameter int BLANK_LINES = 4,
  parameter int H_TOTAL     = 336,
  parameter int H_START     = 7,
  parameter int H_PULSE     = 2,
  parameter int V_PULSE     = 2
)(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic [1:0] mode,
  output logic hsyncN,
  output logic vsyncN,
  output logic de,
  output logic [$clog2(ACT_LINES + BLANK_LINES)-1:0] lineIdx,
  output logic [$clog2(ACT_PIX + 1)-1:0] pixIdx
);

  localparam int LINE_W    = $clog2(ACT_LINES + BLANK_LINES);
  localparam int PIX_W     = $clog2(ACT_PIX + 1);
  localparam int LAST_LINE = ACT_LINES + BLANK_LINES - 1;

  seq_strobe_t strobe;
  fmt_cfg_t    cfg;
  logic        frameEnd;

  lcd_sync_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .mode     (mode),
    .frameEnd (frameEnd),
    .strobe   (strobe),
    .cfg      (cfg)
  );

  lcd_sync_dp #(
    .ACT_PIX     (ACT_PIX),
    .ACT_LINES   (ACT_LINES),
    .BLANK_LINES (BLANK_LINES),
    .H_TOTAL     (H_TOTAL),
    .H_START     (H_START),
    .H_PULSE     (H_PULSE),
    .V_PULSE     (V_PULSE),
    .LINE_W      (LINE_W),
    .PIX_W       (PIX_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cfg      (cfg),
    .frameEnd (frameEnd),
    .hsyncN   (hsyncN),
    .vsyncN   (vsyncN),
    .de       (de),
    .lineIdx  (lineIdx),
    .pixIdx   (pixIdx)
  );

endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk #(
  parameter int LINE_W    = 8,
  parameter int PIX_W     = 9,
  parameter int LAST_LINE = 243
)(
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              hsyncN,
  input logic              vsyncN,
  input logic              de,
  input logic [LINE_W-1:0] lineIdx,
  input logic [PIX_W-1:0]  pixIdx
);

  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (hsyncN && vsyncN && !de && lineIdx == '0 && pixIdx == '0));

  p_vsync_in_hsync_r3: assert property (@(posedge clk) disable iff (rst)
    !vsyncN |-> (!hsyncN && lineIdx == '0));

  p_de_clear_of_sync_r5: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsyncN && vsyncN));

  p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(hsyncN) && $past(lineIdx) != '0 && $past(lineIdx) != LINE_W'(LAST_LINE))
      |-> lineIdx == $past(lineIdx) + LINE_W'(1));

  p_pix_step_r6: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (pixIdx == $past(pixIdx) || pixIdx == $past(pixIdx) + PIX_W'(1)));

  p_pix_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> pixIdx == '0);

endmodule

bind lcd_sync_gen lcd_sync_chk #(
  .LINE_W    (LINE_W),
  .PIX_W     (PIX_W),
  .LAST_LINE (LAST_LINE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .hsyncN  (hsyncN),
  .vsyncN  (vsyncN),
  .de      (de),
  .lineIdx (lineIdx),
  .pixIdx  (pixIdx)
);

// File: tb/lcd_sync_gen_tb.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb;

  localparam int AP = 16, AL = 6, BL = 4, HT = 26, HS = 7, HP = 2, VP = 2;
  localparam int VT = AL + BL;
  localparam int VTOP = BL / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hsyncN, vsyncN, de;
  logic [$clog2(VT)-1:0] lineIdx;
  logic [$clog2(AP+1)-1:0] pixIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_sync_gen #(
    .ACT_PIX(AP), .ACT_LINES(AL), .BLANK_LINES(BL), .H_TOTAL(HT),
    .H_START(HS), .H_PULSE(HP), .V_PULSE(VP)
  ) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .de(de), .lineIdx(lineIdx), .pixIdx(pixIdx)
  );

  // behavioural reference state
  int mRun = 0, mFmt = 0, mH = 0, mV = 0;

  function automatic int cppOf(int f);
    if (f == 1) return 2;
    if (f == 2) return 3;
    return 1;
  endfunction
  function automatic int corrOf(int f);
    if (f == 1) return 3;
    if (f == 2) return 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRun = 0; mFmt = 0; mH = 0; mV = 0;
    end else if (!enable) begin
      mRun = 0; mH = 0; mV = 0;
    end else if (mRun == 0) begin
      mH = 0; mV = 0;
      if (mode != 2'b11) begin mRun = 1; mFmt = int'(mode); end
    end else if (mH == HT * cppOf(mFmt) - 1) begin
      mH = 0;
      if (mV == VT - 1) begin
        mV = 0;
        mFmt = int'(mode);
        mRun = (mode != 2'b11) ? 1 : 0;
      end else mV = mV + 1;
    end else mH = mH + 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, sampled on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      if (mRun == 0) begin
        string t;
        t = rst ? "R10 idle" : (!enable ? "R8 idle" : "R7 idle");
        chk({t, " hsyncN"}, int'(hsyncN), 1);
        chk({t, " vsyncN"}, int'(vsyncN), 1);
        chk({t, " de"}, int'(de), 0);
        chk({t, " lineIdx"}, int'(lineIdx), 0);
        chk({t, " pixIdx"}, int'(pixIdx), 0);
      end else begin
        int c, st, eDe, eHs, eVs, ePix;
        c   = cppOf(mFmt);
        st  = HS * c + corrOf(mFmt);
        eHs = (mH < HP * c) ? 0 : 1;
        eVs = (mV == 0 && mH < VP * c) ? 0 : 1;
        eDe = (mH >= st && mH < st + AP * c && mV >= VTOP && mV < VTOP + AL) ? 1 : 0;
        ePix = eDe ? (mH - st) / c : 0;
        chk("R2 hsyncN", int'(hsyncN), eHs);
        chk("R3 vsyncN", int'(vsyncN), eVs);
        chk("R1 R5 de", int'(de), eDe);
        chk("R4 lineIdx", int'(lineIdx), mV);
        chk("R6 pixIdx", int'(pixIdx), ePix);
      end
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  // width of the next low pulse on hsyncN, in ticks
  task automatic hsyncWidth(output int w);
    w = 0;
    do @(negedge clk); while (hsyncN == 1'b0);
    do @(negedge clk); while (hsyncN == 1'b1);
    while (hsyncN == 1'b0) begin w++; @(negedge clk); end
  endtask

  task automatic vsyncWidth(output int w);
    w = 0;
    do @(negedge clk); while (vsyncN == 1'b1);
    while (vsyncN == 1'b0) begin w++; @(negedge clk); end
  endtask

  initial begin
    int w;
    ticks(4);
    // R10: reset state
    chk("R10 reset hsyncN", int'(hsyncN), 1);
    chk("R10 reset de", int'(de), 0);
    rst = 1'b0;
    ticks(5);
    // R7: reserved code while idle
    mode = 2'b11; enable = 1'b1;
    ticks(50);
    chk("R7 reserved keeps vsyncN high", int'(vsyncN), 1);
    mode = 2'b00;
    ticks(400);
    // R9: mid-frame change to 3 ticks per pixel
    mode = 2'b10;
    hsyncWidth(w);
    chk("R9 hsync width before frame end", w, HP * 1);
    vsyncWidth(w);
    chk("R9 vsync width after frame start", w, VP * 3);
    hsyncWidth(w);
    chk("R1 R2 hsync width 3 ticks per pixel", w, HP * 3);
    ticks(900);
    mode = 2'b01;
    ticks(900);
    // R8: drop and restore enable mid-frame
    enable = 1'b0;
    ticks(20);
    chk("R8 parked lineIdx", int'(lineIdx), 0);
    enable = 1'b1;
    ticks(700);
    // R7: reserved code at the next frame boundary
    mode = 2'b11;
    ticks(1200);
    chk("R7 reserved at frame start idles hsyncN", int'(hsyncN), 1);
    mode = 2'b01;
    ticks(300);
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
    ticks(100);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule